// File: doc/BRIEF.md
# Eight-Pin APB GPIO Port with Address-Masked Data Access

This block is an 8-pin general-purpose I/O port behind an APB slave. Its data register is reached through a window of 256 word addresses. The word address bits act as a per-pin mask, so software can set, clear or sample any subset of pins in one transfer, with no read-modify-write.

Each pin has a direction bit and a mode bit. The mode bit hands the pad to an on-chip alternate-function source instead of the data register. Each pin also has an interrupt detector. It can be set to a rising edge, a falling edge, both edges, a high level or a low level. The detector feeds a raw status register, a masked status register and a single combined interrupt line. Pad inputs pass through a two-flop synchronizer before any logic uses them.

Top module: `gpio_apb_masked`

## Requirements
- R1: After reset, every register reads 0, so all pins are software-controlled inputs: `pin_oe` is 0, `irq` is 0, and a full-mask data read of low pins returns 0.
- R2: A read with `paddr[11:10]==0` is a data read, and `paddr[n+2]` is the mask for pin n. A masked-off bit reads 0. An unmasked output pin (direction 1) returns its data register bit. An unmasked input pin returns the pad level, which becomes visible two clock edges after the pad changes.
- R3: A write in the data window updates only the data register bits whose mask bit is 1. All other bits keep their old value.
- R4: Offset 0x400 is the direction register. In software mode, `pin_oe` equals the direction bit and `pin_out` equals the data register bit.
- R5: Offset 0x420 is the mode register. A pin whose mode bit is 1 drives `pin_out` from `alt_out` and `pin_oe` from `alt_oe`.
- R6: Offset 0x404 selects the sense, with bit 0 for edge and bit 1 for level. Offset 0x40C is the polarity, where 1 means rising or high and 0 means falling or low. In edge mode, a matching edge on the synchronized input sets the sticky raw status bit at 0x414 three clock edges after the pad changes. An edge in the other direction sets nothing.
- R7: Offset 0x408 is the both-edges register. A 1 makes an edge-sensed pin capture either edge, whatever its polarity.
- R8: A level-sensed pin's raw status follows the synchronized level. The bit is 1 while the level matches the polarity and 0 otherwise, and no clear is needed.
- R9: Writing 1 to a bit of 0x41C clears that pin's edge status. Writing 0 leaves it as it is, and a clear has no effect on a level-sensed bit.
- R10: Offset 0x418 reads raw status AND the enable register at 0x410. `irq` is the OR of the masked bits.
- R11: The configuration registers at 0x400 to 0x410 and 0x420 read back what was written. Undefined offsets read 0, and writes to them or to the status registers change nothing. `pready` is always 1 and `pslverr` is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write |
| paddr | input | 12 | Byte address |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Never an error |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output levels |
| pin_oe | output | 8 | Pad output enables |
| alt_out | input | 8 | Alternate-function output values |
| alt_oe | input | 8 | Alternate-function output enables |
| irq | output | 1 | Combined interrupt |

## Verification
Some properties are checked on every cycle. A data write never changes a data bit whose mask bit is 0, and nothing but a data write changes the data register. An edge status bit falls only on a clear write. `irq` is never high while every enable bit is 0. The bus response is always ready and error-free.

Other behaviour needs the bench's scenarios. These are the synchronizer latency, edge versus level versus both-edge capture, the write-1-to-clear rule, alternate-function muxing and the exact read-back values. The bench checks them against a model of the pins and registers, under random data-window traffic and under directed interrupt sequences.

// File: rtl/gpio_apb_masked.sv
module gpio_apb_masked #(
  parameter int N  = 8,
  parameter int AW = 12
) (
  input  logic          pclk,
  input  logic          presetn,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [N-1:0]  pwdata,
  output logic [N-1:0]  prdata,
  output logic          pready,
  output logic          pslverr,
  input  logic [N-1:0]  pin_in,
  output logic [N-1:0]  pin_out,
  output logic [N-1:0]  pin_oe,
  input  logic [N-1:0]  alt_out,
  input  logic [N-1:0]  alt_oe,
  output logic          irq
);
  localparam logic [7:0] IX_DIR   = 8'd0;
  localparam logic [7:0] IX_SENSE = 8'd1;
  localparam logic [7:0] IX_BOTH  = 8'd2;
  localparam logic [7:0] IX_POL   = 8'd3;
  localparam logic [7:0] IX_IE    = 8'd4;
  localparam logic [7:0] IX_RAW   = 8'd5;
  localparam logic [7:0] IX_MSK   = 8'd6;
  localparam logic [7:0] IX_CLR   = 8'd7;
  localparam logic [7:0] IX_MODE  = 8'd8;

  logic [N-1:0] data_q, dir_q, sense_q, both_q, pol_q, ie_q, mode_q, edge_q;
  logic [N-1:0] sync1_q, sync2_q, prev_q;
  logic [N-1:0] edge_hit, lvl_hit, raw, masked, clr_vec, amask, rd_pins;
  logic         wr, in_data, in_regs;
  logic [7:0]   idx;
  logic         unused_addr;

  assign wr      = psel & penable & pwrite;
  assign in_data = (paddr[AW-1:10] == '0);
  assign in_regs = (paddr[AW-1:10] == 1);
  assign idx     = paddr[9:2];
  assign amask   = paddr[N+1:2];
  assign unused_addr = ^paddr[1:0];

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  always_ff @(posedge pclk or negedge presetn)
    if (!presetn) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end

  always_ff @(posedge pclk or negedge presetn)
    if (!presetn) begin
      data_q  <= '0;
      dir_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      ie_q    <= '0;
      mode_q  <= '0;
    end else if (wr) begin
      if (in_data) data_q <= (data_q & ~amask) | (pwdata & amask);
      if (in_regs) begin
        case (idx)
          IX_DIR:   dir_q   <= pwdata;
          IX_SENSE: sense_q <= pwdata;
          IX_BOTH:  both_q  <= pwdata;
          IX_POL:   pol_q   <= pwdata;
          IX_IE:    ie_q    <= pwdata;
          IX_MODE:  mode_q  <= pwdata;
          default: ;
        endcase
      end
    end

  assign clr_vec  = (wr && in_regs && idx == IX_CLR) ? pwdata : '0;
  assign edge_hit = ~sense_q & ((both_q & (sync2_q ^ prev_q)) |
                    (~both_q & pol_q & sync2_q & ~prev_q) |
                    (~both_q & ~pol_q & ~sync2_q & prev_q));
  assign lvl_hit  = (pol_q & sync2_q) | (~pol_q & ~sync2_q);

  always_ff @(posedge pclk or negedge presetn)
    if (!presetn) edge_q <= '0;
    else          edge_q <= (edge_q & ~clr_vec) | edge_hit;

  assign raw    = (sense_q & lvl_hit) | (~sense_q & edge_q);
  assign masked = raw & ie_q;
  assign irq    = |masked;

  assign pin_out = (mode_q & alt_out) | (~mode_q & data_q);
  assign pin_oe  = (mode_q & alt_oe)  | (~mode_q & dir_q);
  assign rd_pins = (dir_q & data_q) | (~dir_q & sync2_q);

  always_comb begin
    prdata = '0;
    if (in_data) prdata = rd_pins & amask;
    else if (in_regs) begin
      case (idx)
        IX_DIR:   prdata = dir_q;
        IX_SENSE: prdata = sense_q;
        IX_BOTH:  prdata = both_q;
        IX_POL:   prdata = pol_q;
        IX_IE:    prdata = ie_q;
        IX_RAW:   prdata = raw;
        IX_MSK:   prdata = masked;
        IX_MODE:  prdata = mode_q;
        default:  prdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_apb_masked_chk.sv
module gpio_apb_masked_chk #(
  parameter int N = 8
) (
  input logic         pclk,
  input logic         presetn,
  input logic         wr,
  input logic         in_data,
  input logic [N-1:0] amask,
  input logic [N-1:0] data_q,
  input logic [N-1:0] edge_q,
  input logic [N-1:0] clr_vec,
  input logic [N-1:0] ie_q,
  input logic         irq,
  input logic         pready,
  input logic         pslverr
);
  AST_MASKED_WRITE: assert property (@(posedge pclk) disable iff (!presetn)
    (wr && in_data) |=> (((data_q ^ $past(data_q)) & ~$past(amask)) == '0)); // R3
  AST_DATA_HOLD: assert property (@(posedge pclk) disable iff (!presetn)
    !(wr && in_data) |=> $stable(data_q)); // R3
  AST_EDGE_STICKY: assert property (@(posedge pclk) disable iff (!presetn)
    (clr_vec == '0) |=> (($past(edge_q) & ~edge_q) == '0)); // R9
  AST_IRQ_NEEDS_IE: assert property (@(posedge pclk) disable iff (!presetn)
    irq |-> (ie_q != '0)); // R10
  AST_BUS_OK: assert property (@(posedge pclk) disable iff (!presetn)
    pready && !pslverr); // R11
endmodule

bind gpio_apb_masked gpio_apb_masked_chk #(.N(N)) u_chk (
  .pclk(pclk), .presetn(presetn), .wr(wr), .in_data(in_data),
  .amask(amask), .data_q(data_q), .edge_q(edge_q), .clr_vec(clr_vec),
  .ie_q(ie_q), .irq(irq), .pready(pready), .pslverr(pslverr)
);

// File: tb/tb_gpio_apb_masked.sv
`timescale 1ns/1ps
module tb_gpio_apb_masked;
  logic        pclk = 0, presetn = 0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [7:0]  pwdata = '0, prdata, pin_in = '0, pin_out, pin_oe;
  logic [7:0]  alt_out = '0, alt_oe = '0;
  logic        pready, pslverr, irq;
  int errors = 0, checks = 0;
  logic [7:0] exp_data = '0, exp_dir = '0, rd;

  always #2.5 pclk = ~pclk;

  gpio_apb_masked dut (.*);

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge pclk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge pclk); penable = 1; #1 d = prdata;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic settle; repeat (4) @(negedge pclk); endtask

  function automatic logic [11:0] daddr(input logic [7:0] m);
    return {2'b00, m, 2'b00};
  endfunction
  function automatic logic [7:0] exp_read(input logic [7:0] m, input logic [7:0] pins);
    return m & ((exp_dir & exp_data) | (~exp_dir & pins));
  endfunction

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge pclk);
    presetn = 1;
    settle();
    for (int k = 0; k < 10; k++) begin
      apb_rd(12'h400 + 12'(4 * k), rd); chk("R1 reg reset", rd, 8'h00);
    end
    apb_rd(daddr(8'hFF), rd); chk("R1 data reset", rd, 8'h00);
    #1 chk("R1 oe reset", pin_oe, 8'h00); chk("R1 irq reset", {7'd0, irq}, 8'h00);

    // R11 readback of configuration registers
    for (int k = 0; k < 5; k++) begin
      apb_wr(12'h400 + 12'(4 * k), 8'h11 * 8'(k + 3));
      apb_rd(12'h400 + 12'(4 * k), rd); chk("R11 readback", rd, 8'h11 * 8'(k + 3));
      apb_wr(12'h400 + 12'(4 * k), 8'h00);
    end
    apb_wr(12'h420, 8'h5A); apb_rd(12'h420, rd); chk("R11 mode readback", rd, 8'h5A);
    apb_wr(12'h420, 8'h00);

    // R2 R3 R4 random data-window traffic
    for (int it = 0; it < 60; it++) begin
      logic [7:0] m, v, rm;
      m = 8'($urandom); v = 8'($urandom); rm = 8'($urandom);
      if (it % 8 == 0) begin
        exp_dir = 8'($urandom); apb_wr(12'h400, exp_dir);
      end
      pin_in = 8'($urandom);
      if (it == 5) m = 8'h00;
      if (it == 6) m = 8'hFF;
      apb_wr(daddr(m), v);
      exp_data = (exp_data & ~m) | (v & m);
      settle();
      apb_rd(daddr(rm), rd); chk("R2 R3 masked read", rd, exp_read(rm, pin_in));
      #1 chk("R4 pin_out", pin_out, exp_data); chk("R4 pin_oe", pin_oe, exp_dir);
    end
    // R2 synchronizer latency: unchanged after one edge, updated after two
    exp_dir = 8'h00; apb_wr(12'h400, 8'h00);
    pin_in = 8'h00; settle();
    @(negedge pclk); psel = 1; paddr = daddr(8'hFF); penable = 1; pin_in = 8'hC3;
    @(negedge pclk); #1 chk("R2 one edge", prdata, 8'h00);
    @(negedge pclk); #1 chk("R2 two edges", prdata, 8'hC3);
    psel = 0; penable = 0;

    // R5 alternate function
    exp_dir = 8'hFF; apb_wr(12'h400, 8'hFF); apb_wr(daddr(8'hFF), 8'h0F);
    alt_out = 8'hA5; alt_oe = 8'h3C; apb_wr(12'h420, 8'hF0);
    #1 chk("R5 pin_out", pin_out, 8'hAF); chk("R5 pin_oe", pin_oe, 8'h3F);
    apb_wr(12'h420, 8'h00); apb_wr(12'h400, 8'h00);

    // R6 edge capture, R9 clear
    apb_wr(12'h40C, 8'h01);
    pin_in = 8'h02; settle(); apb_wr(12'h41C, 8'hFF);
    apb_rd(12'h414, rd); chk("R9 clear all", rd, 8'h00);
    pin_in = 8'h01; settle();
    apb_rd(12'h414, rd); chk("R6 rise pin0 fall pin1", rd, 8'h03);
    apb_wr(12'h41C, 8'h01); apb_rd(12'h414, rd); chk("R9 clear one bit", rd, 8'h02);
    apb_wr(12'h41C, 8'h02); apb_rd(12'h414, rd); chk("R9 clear other", rd, 8'h00);
    pin_in = 8'h02; settle();
    apb_rd(12'h414, rd); chk("R6 wrong direction ignored", rd, 8'h00);

    // R7 both edges on pin2
    apb_wr(12'h408, 8'h04);
    pin_in = 8'h06; settle(); apb_rd(12'h414, rd); chk("R7 both rise", rd, 8'h04);
    apb_wr(12'h41C, 8'h04);
    pin_in = 8'h02; settle(); apb_rd(12'h414, rd); chk("R7 both fall", rd, 8'h04);
    apb_wr(12'h41C, 8'h04);

    // R8 level on pin3 (high)
    apb_wr(12'h404, 8'h08); apb_wr(12'h40C, 8'h09);
    apb_rd(12'h414, rd); chk("R8 level low", rd, 8'h00);
    pin_in = 8'h0A; settle(); apb_rd(12'h414, rd); chk("R8 level high", rd, 8'h08);
    apb_wr(12'h41C, 8'h08); apb_rd(12'h414, rd); chk("R9 level not cleared", rd, 8'h08);
    pin_in = 8'h02; settle(); apb_rd(12'h414, rd); chk("R8 level follows", rd, 8'h00);
    apb_wr(12'h404, 8'h00);

    // R10 masked status and irq
    apb_wr(12'h41C, 8'hFF); apb_wr(12'h410, 8'h04);
    #1 chk("R10 irq idle", {7'd0, irq}, 8'h00);
    pin_in = 8'h06; settle();
    apb_rd(12'h418, rd); chk("R10 masked", rd, 8'h04);
    #1 chk("R10 irq set", {7'd0, irq}, 8'h01);
    apb_wr(12'h410, 8'h00);
    apb_rd(12'h418, rd); chk("R10 masked off", rd, 8'h00);
    #1 chk("R10 irq masked", {7'd0, irq}, 8'h00);
    apb_rd(12'h414, rd); chk("R10 raw kept", rd, 8'h04);

    // R11 undefined offsets and read-only writes
    apb_wr(12'h414, 8'h00); apb_rd(12'h414, rd); chk("R11 raw write ignored", rd, 8'h04);
    apb_wr(12'h424, 8'hFF); apb_rd(12'h424, rd); chk("R11 undefined read", rd, 8'h00);
    apb_wr(12'h800, 8'hFF); apb_rd(12'h800, rd); chk("R11 high range read", rd, 8'h00);
    #1 chk("R11 undefined write no effect", pin_oe, 8'h00);
    chk("R11 bus", {6'd0, pready, pslverr}, 8'h02);
    summary();
  end
endmodule